// File: doc/BRIEF.md
# Register Block Transfer Sequencer

This block moves a group of registers to or from memory in response to one command. The command carries a 16-bit selection mask (one bit per register), a word-aligned start address, a direction (load from memory or store to memory), an address phase choice (increment before or after each access), and a flag that asks for the updated start address to be written back. The sequencer walks the mask from the lowest selected register to the highest. For each one it issues a single word access at consecutive ascending addresses, at most one per cycle.

The sequencer reads and writes the register file through a combinational read port and a write port. It talks to memory over a plain request/ready interface. Memory can insert wait states by holding ready low. While it does, the request and its address and data stay frozen. When the last word has been taken, a one-cycle done pulse reports completion. In the same cycle the sequencer presents the advanced address (start plus four bytes per selected register) and a write strobe when write-back was requested. An empty mask makes no memory access and finishes at once.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, `busy`, `mem_req`, `done`, `rf_we` and `base_we` are all low.
- R2: `cmd_valid` is accepted only while `busy` is low. While a transfer runs, a new `cmd_valid` has no effect: the running transfer makes exactly its own number of accesses, and `busy` is low in the cycle after `done`.
- R3: Selected registers are transferred in ascending register number. Mask bit i selects register i. Each access address is 4 higher than the previous one.
- R4: With `cmd_pre`=0 the first access address is the command address. With `cmd_pre`=1 it is the command address plus 4.
- R5: When memory never stalls, an n-register transfer makes one access per cycle. The n accesses fall in the n cycles that follow acceptance, and `done` is high in the cycle after that (n+1 cycles after acceptance).
- R6: While `mem_req` is high and `mem_ready` is low, the next cycle keeps `mem_req` high with the same `mem_addr`.
- R7: For a store (`cmd_load`=0), each access has `mem_we`=1 and `mem_wdata` equal to the contents of the register being transferred.
- R8: For a load (`cmd_load`=1), `mem_we`=0, and `rf_we` is high exactly in each cycle where `mem_req` and `mem_ready` are both high. In that cycle `rf_waddr` is the register number and `rf_wdata` equals `mem_rdata`.
- R9: `done` is a one-cycle pulse. In that cycle `base_out` equals the command address plus 4 times the number of set mask bits. `base_we` is high in that cycle only if `cmd_wb` was 1.
- R10: An all-zero mask makes no memory access, and `done` is high in the cycle after acceptance.
- R11: Every access address has its two low bits at zero, provided the command address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Start a transfer (taken when not busy) |
| cmd_mask | input | 16 | Register selection, bit i = register i |
| cmd_addr | input | 32 | Word-aligned start address |
| cmd_load | input | 1 | 1 = memory to registers, 0 = registers to memory |
| cmd_pre | input | 1 | 1 = increment before each access, 0 = after |
| cmd_wb | input | 1 | Request write-back of the advanced address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts/completes the access this cycle |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| base_we | output | 1 | Write strobe for the advanced address |
| base_out | output | 32 | Advanced address (start + 4 x count) |

## Verification
The bench aims at the edges of the mask: the empty mask, register 0 and register 15 both selected, a single bit, and the full mask. A walker that skipped or repeated a bit shows up there as a wrong register number or a wrong access count. Both address phases are run: an off-by-one phase shifts every address by four and also gets the advanced address wrong. Random memory stalls test whether the request holds its address through a wait state or moves past a word that was not taken. Commands asserted mid-transfer test whether a second start slips in early.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MOVE = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/xfer_mask_walk.sv
// Picks the lowest selected register and the mask left after it.
module xfer_mask_walk #(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask,
  output logic [IW-1:0]   idx,
  output logic [NREG-1:0] rest,
  output logic            last
);
  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end

  assign rest = mask & (mask - NREG'(1));
  assign last = (rest == '0);
endmodule

// File: rtl/xfer_span_calc.sv
// First access address and advanced address for a command.
module xfer_span_calc #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] mask,
  input  logic [AW-1:0]   base,
  input  logic            pre,
  output logic [AW-1:0]   first_addr,
  output logic [AW-1:0]   final_addr
);
  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) begin
      cnt = cnt + CW'(mask[i]);
    end
  end

  assign first_addr = pre ? base + AW'(4) : base;
  assign final_addr = base + (AW'(cnt) << 2);
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [NREG-1:0] cmd_mask,
  input  logic [AW-1:0]   cmd_addr,
  input  logic            cmd_load,
  input  logic            cmd_pre,
  input  logic            cmd_wb,
  output logic            busy,
  output logic            done,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ready,
  output logic [IW-1:0]   rf_raddr,
  input  logic [DW-1:0]   rf_rdata,
  output logic            rf_we,
  output logic [IW-1:0]   rf_waddr,
  output logic [DW-1:0]   rf_wdata,
  output logic            base_we,
  output logic [AW-1:0]   base_out
);
  seq_state_e      state_q, state_d;
  logic [NREG-1:0] mask_q, mask_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [AW-1:0]   final_q;
  logic            load_q, wb_q;
  logic            accept, step, cmd_en;

  logic [IW-1:0]   cur_idx;
  logic [NREG-1:0] mask_rest;
  logic            mask_last;
  logic [AW-1:0]   span_first, span_final;

  xfer_mask_walk #(.NREG(NREG)) u_walk (
    .mask (mask_q),
    .idx  (cur_idx),
    .rest (mask_rest),
    .last (mask_last)
  );

  xfer_span_calc #(.NREG(NREG), .AW(AW)) u_span (
    .mask       (cmd_mask),
    .base       (cmd_addr),
    .pre        (cmd_pre),
    .first_addr (span_first),
    .final_addr (span_final)
  );

  assign accept = (state_q == ST_IDLE) && cmd_valid;
  assign step   = (state_q == ST_MOVE) && mem_ready;
  assign cmd_en = accept;

  // Next-state process
  always_comb begin
    state_d = state_q;
    mask_d  = mask_q;
    addr_d  = addr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          mask_d  = cmd_mask;
          addr_d  = span_first;
          state_d = (cmd_mask == '0) ? ST_FIN : ST_MOVE;
        end
      end
      ST_MOVE: begin
        if (mem_ready) begin
          mask_d = mask_rest;
          addr_d = addr_q + AW'(4);
          if (mask_last) state_d = ST_FIN;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept || step) begin
        mask_q <= mask_d;
        addr_q <= addr_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      final_q <= '0;
      load_q  <= 1'b0;
      wb_q    <= 1'b0;
    end else if (cmd_en) begin
      final_q <= span_final;
      load_q  <= cmd_load;
      wb_q    <= cmd_wb;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign mem_req   = (state_q == ST_MOVE);
  assign mem_we    = mem_req && !load_q;
  assign mem_addr  = addr_q;
  assign rf_raddr  = cur_idx;
  assign mem_wdata = rf_rdata;
  assign rf_we     = step && load_q;
  assign rf_waddr  = cur_idx;
  assign rf_wdata  = mem_rdata;
  assign base_we   = done && wb_q;
  assign base_out  = final_q;

  // R6: a stalled request stays up with the same address
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(rf_raddr)));

  // R3: back-to-back accesses step by one word
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> (!mem_req || mem_addr == $past(mem_addr) + AW'(4)));

  // R11: word alignment
  a_r11_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R8: register writes only on taken load accesses
  a_r8_rf_write: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (mem_req && mem_ready && !mem_we));

  // R9: done is a single pulse ending the transfer
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R9: write-back strobe only with done
  a_r9_base_we: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |-> (done && !mem_req));
endmodule

// File: tb/blk_xfer_seq_bench.sv
module blk_xfer_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [15:0] cmd_mask;
  logic [31:0] cmd_addr;
  logic        cmd_load, cmd_pre, cmd_wb;
  logic        busy, done, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata;
  logic        rf_we, base_we;
  logic [31:0] base_out;

  logic [31:0] rf_m [16];
  logic [31:0] mem_m [256];

  int checks = 0;
  int errors = 0;

  logic        mon_on = 1'b0;
  logic        stall_mode = 1'b0;
  logic [15:0] rem;
  logic [31:0] exp_addr;
  logic        cur_load;
  logic        first_acc;
  int          hs;
  logic        stall_pend;
  logic [31:0] stall_addr;

  always #4 clk = ~clk;

  blk_xfer_seq u_blk_xfer_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mask(cmd_mask),
    .cmd_addr(cmd_addr), .cmd_load(cmd_load), .cmd_pre(cmd_pre), .cmd_wb(cmd_wb),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .base_we(base_we), .base_out(base_out)
  );

  assign rf_rdata  = rf_m[rf_raddr];
  assign mem_rdata = mem_m[mem_addr[9:2]];

  always @(posedge clk) begin
    if (rf_we) rf_m[rf_waddr] <= rf_wdata;
    if (mem_req && mem_we && mem_ready) mem_m[mem_addr[9:2]] <= mem_wdata;
    mem_ready <= stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] low_bit(input logic [15:0] m);
    logic [3:0] r = 4'd0;
    for (int i = 15; i >= 0; i--) if (m[i]) r = 4'(i);
    return r;
  endfunction

  function automatic int pop16(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(m[i]);
    return c;
  endfunction

  // Access monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (mem_req) begin
        if (stall_pend) chk(mem_addr == stall_addr, "R6 held addr", mem_addr, stall_addr);
        if (mem_ready) begin
          logic [3:0] ei;
          ei = low_bit(rem);
          chk(rem != 16'h0, "R2 extra access", 32'(rem), 32'h1);
          chk(mem_addr == exp_addr, first_acc ? "R4 first addr" : "R3 addr", mem_addr, exp_addr);
          chk(mem_we == !cur_load, "R7/R8 mem_we", 32'(mem_we), 32'(!cur_load));
          if (!cur_load) begin
            chk(rf_raddr == ei, "R3 reg order", 32'(rf_raddr), 32'(ei));
            chk(mem_wdata == rf_m[ei], "R7 store data", mem_wdata, rf_m[ei]);
          end else begin
            chk(rf_we && rf_waddr == ei, "R8 write index", {rf_we, 27'd0, rf_waddr}, {1'b1, 27'd0, ei});
            chk(rf_wdata == mem_m[exp_addr[9:2]], "R8 load data", rf_wdata, mem_m[exp_addr[9:2]]);
          end
          rem = rem & (rem - 16'd1);
          exp_addr = exp_addr + 32'd4;
          first_acc = 1'b0;
          hs++;
          stall_pend = 1'b0;
        end else begin
          stall_pend = 1'b1;
          stall_addr = mem_addr;
        end
      end else if (stall_pend) begin
        chk(1'b0, "R6 request dropped", 32'd0, 32'd1);
        stall_pend = 1'b0;
      end
      if (rf_we && !(mem_req && mem_ready && cur_load))
        chk(1'b0, "R8 stray rf_we", 32'd1, 32'd0);
    end
  end

  task automatic run_cmd(input logic [15:0] m, input logic [31:0] b, input bit ld,
                         input bit pr, input bit wb, input bit stl, input bit inject);
    int cyc = 0;
    int n = pop16(m);
    @(negedge clk);
    stall_mode = stl;
    cmd_mask = m; cmd_addr = b; cmd_load = ld; cmd_pre = pr; cmd_wb = wb;
    cmd_valid = 1'b1;
    rem = m; exp_addr = pr ? b + 32'd4 : b; cur_load = ld; first_acc = 1'b1;
    hs = 0; stall_pend = 1'b0; mon_on = 1'b1;
    @(posedge clk);
    #1;
    if (inject) begin
      cmd_mask = ~m; cmd_addr = b + 32'd64; cmd_load = !ld; // ignored while busy (R2)
    end else begin
      cmd_valid = 1'b0;
    end
    forever begin
      @(negedge clk);
      cyc++;
      if (done) break;
      if (cyc > 3000) begin
        chk(1'b0, "R9 watchdog no done", 32'(cyc), 32'(n + 1));
        break;
      end
      chk(busy, "R2 busy during transfer", 32'(busy), 32'd1);
    end
    cmd_valid = 1'b0;
    if (!stl) chk(cyc == n + 1, (n == 0) ? "R10 done latency" : "R5 done latency", 32'(cyc), 32'(n + 1));
    chk(hs == n, (n == 0) ? "R10 access count" : "R2 access count", 32'(hs), 32'(n));
    chk(base_out == b + 32'(4 * n), "R9 base_out", base_out, b + 32'(4 * n));
    chk(base_we == wb, "R9 base_we", 32'(base_we), 32'(wb));
    @(negedge clk);
    chk(!busy && !done, "R2/R9 idle after done", {31'd0, busy | done}, 32'd0);
    mon_on = 1'b0;
    stall_mode = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < 16; i++) rf_m[i] = $urandom;
    for (int i = 0; i < 256; i++) mem_m[i] = $urandom;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_mask = '0; cmd_addr = '0;
    cmd_load = 1'b0; cmd_pre = 1'b0; cmd_wb = 1'b0; mem_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !done && !rf_we && !base_we, "R1 reset state",
        {27'd0, busy, mem_req, done, rf_we, base_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req && !done, "R1 idle after release", {29'd0, busy, mem_req, done}, 32'd0);

    run_cmd(16'h0000, 32'h100, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);  // R10 empty mask
    run_cmd(16'hFFFF, 32'h080, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);  // R4 full load, pre
    run_cmd(16'h8001, 32'h040, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);  // R3 ends of mask, store
    run_cmd(16'h0010, 32'h200, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);  // R2 inject while busy
    run_cmd(16'hFFFF, 32'h000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);  // R6 full store, stalls
    for (int k = 0; k < 40; k++) begin
      logic [15:0] m;
      m = (k % 9 == 0) ? 16'h0 : 16'($urandom);
      run_cmd(m, {22'd0, 8'($urandom_range(0, 120)), 2'b00}, 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), (k % 5 == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    chk(1'b0, "R5 global watchdog", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule